// File: doc/BRIEF.md
# Peripheral Reset Controller

This block sits on an APB bus and owns the reset lines of a set of peripherals, one active-high line each. Software sets a bit in the hold register to keep a peripheral in reset and clears it to let the peripheral run. Every line comes out of system reset asserted, so nothing runs until software releases it.

A second register holds a watchdog mask. When the watchdog-fire input pulses, every peripheral whose mask bit is set goes back into reset and stays there until software clears its hold bit again. A third, read-only register reports the completion handshake that each peripheral returns. Each handshake passes through a two-flop synchronizer, and a peripheral that is still held in reset always reads as not ready. Software polls this register before it touches the peripheral's own registers.

Top module: `periph_rst_ctrl`

## Requirements
- R1: After system reset, `periph_rst` is all ones (hold register reads 0x01FFFFFF), the watchdog mask reads 0 and the ready register reads 0.
- R2: The register map is: hold at offset 0x0, watchdog mask at 0x4, ready status at 0x8. Bit n (n = 0..24) of each register belongs to peripheral n, and bits 31:25 always read as 0.
- R3: A write to offset 0x0 in the access phase (psel, penable and pwrite all high) loads pwdata[24:0] into the hold register. `periph_rst` shows the new value from the clock edge that ends that access phase.
- R4: The watchdog mask at offset 0x4 is read-write and reads back pwdata[24:0] from its last write.
- R5: On a cycle with `wdog_fire` high, every hold bit whose mask bit is set becomes 1 at that edge and the other hold bits keep their value. If a hold-register write lands on the same edge, the written value is applied first and the masked bits are then forced to 1.
- R6: Bit n of the ready register equals `done_in[n]` as sampled two clock edges earlier, ANDed with the inverse of hold bit n, so a peripheral held in reset reads 0.
- R7: Writes to offset 0x8 or to any offset other than 0x0 and 0x4 change no state. Reads of an unmapped offset return 0, and `prdata` is 0 while `psel` is low.
- R8: `pready` is always 1 and `pslverr` is always 0.
- R9: A setup phase alone (psel high with penable low) writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low system reset |
| paddr | input | 12 | APB byte address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| wdog_fire | input | 1 | Watchdog event pulse |
| done_in | input | 25 | Completion handshakes from the peripherals |
| periph_rst | output | 25 | Active-high peripheral reset lines |

## Verification
Each result has a fixed latency. A hold-register write or a watchdog pulse shows on `periph_rst` at the edge that samples it. A mask write can be read back in the cycle after that edge. A change on `done_in` reaches the ready register only after two edges, and `prdata` follows the address with no register in between. The bench's reference model applies every input at the posedge with exactly these delays. It compares `periph_rst`, `prdata`, `pready` and `pslverr` 2 ns after each rising edge, when both the model and the design have settled and the inputs, which change only at the falling edge, are stable.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Register offsets; software depends on these values.
    localparam logic [11:0] PRC_OFS_HOLD  = 12'h000;
    localparam logic [11:0] PRC_OFS_WMASK = 12'h004;
    localparam logic [11:0] PRC_OFS_READY = 12'h008;

    localparam int unsigned PRC_NPERIPH   = 25;
    localparam int unsigned PRC_SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_HOLD,
        RSEL_WMASK,
        RSEL_READY
    } prc_rsel_e;

endpackage

// File: rtl/prc_decode.sv
module prc_decode
    import prc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output prc_rsel_e         rsel
);
    always_comb begin
        if (addr == ADDR_W'(PRC_OFS_HOLD)) begin
            rsel = RSEL_HOLD;
        end else if (addr == ADDR_W'(PRC_OFS_WMASK)) begin
            rsel = RSEL_WMASK;
        end else if (addr == ADDR_W'(PRC_OFS_READY)) begin
            rsel = RSEL_READY;
        end else begin
            rsel = RSEL_NONE;
        end
    end
endmodule

// File: rtl/prc_regs.sv
module prc_regs #(
    parameter int unsigned N = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hold,
    input  logic         wr_wmask,
    input  logic [N-1:0] wdata,
    input  logic         wdog,
    output logic [N-1:0] hold_q,
    output logic [N-1:0] wmask_q
);
    typedef struct packed {
        logic [N-1:0] hold;
        logic [N-1:0] wmask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hold) begin
            st_d.hold = wdata;
        end
        if (wr_wmask) begin
            st_d.wmask = wdata;
        end
        // The watchdog uses the mask as it stood before this edge and wins
        // over a same-cycle write for the masked bits.
        if (wdog) begin
            st_d.hold = st_d.hold | st_q.wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold  <= '1;
            st_q.wmask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q  = st_q.hold;
    assign wmask_q = st_q.wmask;
endmodule

// File: rtl/prc_done_sync.sv
module prc_done_sync #(
    parameter int unsigned N      = 25,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg_d [STAGES];
    logic [N-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/prc_rdmux.sv
module prc_rdmux
    import prc_pkg::*;
#(
    parameter int unsigned N      = 25,
    parameter int unsigned DATA_W = 32
) (
    input  logic              sel,
    input  prc_rsel_e         rsel,
    input  logic [N-1:0]      hold,
    input  logic [N-1:0]      wmask,
    input  logic [N-1:0]      done_sync,
    output logic [DATA_W-1:0] rdata
);
    logic [N-1:0] ready_vis;

    // A peripheral still held in reset never reports ready.
    assign ready_vis = done_sync & ~hold;

    always_comb begin
        rdata = '0;
        if (sel) begin
            unique case (rsel)
                RSEL_HOLD:  rdata = DATA_W'(hold);
                RSEL_WMASK: rdata = DATA_W'(wmask);
                RSEL_READY: rdata = DATA_W'(ready_vis);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/periph_rst_ctrl.sv
module periph_rst_ctrl
    import prc_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = PRC_NPERIPH,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SYNC_LEN   = PRC_SYNC_LEN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W-1:0]     prdata,
    output logic                  pready,
    output logic                  pslverr,
    input  logic                  wdog_fire,
    input  logic [NUM_PERIPH-1:0] done_in,
    output logic [NUM_PERIPH-1:0] periph_rst
);
    prc_rsel_e             rsel;
    logic                  acc_wr;
    logic                  wr_hold;
    logic                  wr_wmask;
    logic [NUM_PERIPH-1:0] hold_q;
    logic [NUM_PERIPH-1:0] wsel_q;
    logic [NUM_PERIPH-1:0] done_sync;

    prc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .rsel (rsel)
    );

    assign acc_wr   = psel & penable & pwrite;
    assign wr_hold  = acc_wr & (rsel == RSEL_HOLD);
    assign wr_wmask = acc_wr & (rsel == RSEL_WMASK);

    prc_regs #(.N(NUM_PERIPH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hold  (wr_hold),
        .wr_wmask (wr_wmask),
        .wdata    (pwdata[NUM_PERIPH-1:0]),
        .wdog     (wdog_fire),
        .hold_q   (hold_q),
        .wmask_q  (wsel_q)
    );

    prc_done_sync #(.N(NUM_PERIPH), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (done_in),
        .dout  (done_sync)
    );

    prc_rdmux #(.N(NUM_PERIPH), .DATA_W(DATA_W)) u_rd (
        .sel       (psel),
        .rsel      (rsel),
        .hold      (hold_q),
        .wmask     (wsel_q),
        .done_sync (done_sync),
        .rdata     (prdata)
    );

    assign periph_rst = hold_q;
    assign pready     = 1'b1;
    assign pslverr    = 1'b0;
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
    parameter int unsigned N  = 25,
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] paddr,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [DW-1:0] pwdata,
    input logic [DW-1:0] prdata,
    input logic          wdog_fire,
    input logic [N-1:0]  periph_rst,
    input logic [N-1:0]  wsel_q
);
    logic wr_hold_c;
    logic mapped_c;
    assign wr_hold_c = psel && penable && pwrite && (paddr == AW'(0));
    assign mapped_c  = (paddr == AW'(0)) || (paddr == AW'(4)) || (paddr == AW'(8));

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold_c && !wdog_fire) |=> (periph_rst == $past(pwdata[N-1:0]))); // R3

    AST_WDOG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_fire |=> ((periph_rst & $past(wsel_q)) == $past(wsel_q))); // R5

    AST_WDOG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_fire && !wr_hold_c) |=>
        ((periph_rst & ~$past(wsel_q)) == ($past(periph_rst) & ~$past(wsel_q)))); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_fire && !wr_hold_c) |=> $stable(periph_rst)); // R9

    AST_READY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && (paddr == AW'(8))) |-> ((prdata[N-1:0] & periph_rst) == '0)); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> (prdata[DW-1:N] == '0)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!psel || !mapped_c) |-> (prdata == '0)); // R7
endmodule

bind periph_rst_ctrl prc_checker #(.N(NUM_PERIPH), .AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .paddr      (paddr),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .wdog_fire  (wdog_fire),
    .periph_rst (periph_rst),
    .wsel_q     (wsel_q)
);

// File: tb/periph_rst_ctrl_bench.sv
module periph_rst_ctrl_bench;
    localparam int N = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] paddr = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        wdog_fire = 1'b0;
    logic [N-1:0] done_in = '0;
    logic [N-1:0] periph_rst;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";
    bit done_flag = 0;

    always #4 clk = ~clk;

    periph_rst_ctrl u_periph_rst_ctrl (
        .clk(clk), .rst_n(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .wdog_fire(wdog_fire), .done_in(done_in),
        .periph_rst(periph_rst)
    );

    // Behavioural reference model.
    logic [N-1:0] m_hold = '1, m_mask = '0;
    logic [N-1:0] m_pipe [$];

    always @(posedge clk) begin
        logic [N-1:0] nh;
        if (!rst_n) begin
            m_hold = '1;
            m_mask = '0;
            m_pipe = {'0, '0};
        end else begin
            nh = m_hold;
            if (psel && penable && pwrite && paddr == 12'h000) nh = pwdata[N-1:0];
            if (wdog_fire) nh = nh | m_mask;
            if (psel && penable && pwrite && paddr == 12'h004) m_mask = pwdata[N-1:0];
            m_hold = nh;
            m_pipe.push_back(done_in);
            void'(m_pipe.pop_front());
        end
    end

    function automatic logic [31:0] model_read();
        if (!psel) return 32'h0;
        case (paddr)
            12'h000: return 32'(m_hold);
            12'h004: return 32'(m_mask);
            12'h008: return 32'(m_pipe[0] & ~m_hold);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every clock, 2 ns after the rising edge.
    always @(posedge clk) begin
        if (rst_n && !done_flag) begin
            #2;
            check(cur_req, "periph_rst", 32'(periph_rst), 32'(m_hold));
            check(cur_req, "prdata", prdata, model_read());
            check("R8", "pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d, input bit wd = 0);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; wdog_fire = wd;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; wdog_fire = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 check(tag, "directed read", prdata, exp);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        check("R1", "periph_rst after reset", 32'(periph_rst), 32'h01FF_FFFF);
        apb_read(12'h000, 32'h01FF_FFFF, "R1");
        apb_read(12'h004, 32'h0, "R1");
        apb_read(12'h008, 32'h0, "R1");
        // R3 / R2 hold register
        cur_req = "R3";
        apb_write(12'h000, 32'h0000_0000);
        check("R3", "release all", 32'(periph_rst), 32'h0);
        apb_write(12'h000, 32'h00AA_55C3);
        apb_read(12'h000, 32'h00AA_55C3, "R3");
        cur_req = "R2";
        apb_write(12'h000, 32'hFFFF_FFFF);
        apb_read(12'h000, 32'h01FF_FFFF, "R2");
        // R9 setup phase only
        cur_req = "R9";
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h000; pwdata = 32'h0;
        idle(2); psel = 0; pwrite = 0;
        check("R9", "setup-only write", 32'(periph_rst), 32'h01FF_FFFF);
        // R4 mask register
        cur_req = "R4";
        apb_write(12'h004, 32'hF123_4567);
        apb_read(12'h004, 32'h0123_4567, "R4");
        // R6 ready register
        cur_req = "R6";
        apb_write(12'h000, 32'h0000_0000);
        done_in = '1;
        @(negedge clk); psel = 1; pwrite = 0; paddr = 12'h008;
        idle(4);
        check("R6", "ready all", prdata, 32'h01FF_FFFF);
        psel = 0;
        apb_write(12'h000, 32'h0000_0010);
        apb_read(12'h008, 32'h01FF_FFEF, "R6");
        done_in = 25'h0F0_F0F0;
        idle(3);
        apb_read(12'h008, 32'h00F0_F0E0, "R6");
        // R5 watchdog
        cur_req = "R5";
        apb_write(12'h000, 32'h0000_0000);
        apb_write(12'h004, 32'h0000_0F0F);
        apb_write(12'h000, 32'h0100_0000);
        @(negedge clk); wdog_fire = 1;
        @(negedge clk); wdog_fire = 0;
        check("R5", "after watchdog", 32'(periph_rst), 32'h0100_0F0F);
        idle(3);
        check("R5", "held after watchdog", 32'(periph_rst), 32'h0100_0F0F);
        apb_write(12'h000, 32'h0000_0000, 1);
        check("R5", "write with watchdog", 32'(periph_rst), 32'h0000_0F0F);
        apb_write(12'h000, 32'h0000_0000);
        check("R5", "software clear", 32'(periph_rst), 32'h0);
        // R7 ignored writes and unmapped reads
        cur_req = "R7";
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_write(12'h010, 32'hFFFF_FFFF);
        apb_write(12'h00C, 32'hFFFF_FFFF);
        check("R7", "no effect on lines", 32'(periph_rst), 32'h0);
        apb_read(12'h004, 32'h0000_0F0F, "R7");
        apb_read(12'h010, 32'h0, "R7");
        apb_read(12'h1FC, 32'h0, "R7");
        idle(2);
        cur_req = "R1";
        rst_n = 0;
        idle(2);
        check("R1", "re-reset", 32'(periph_rst), 32'h01FF_FFFF);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule